// File: doc/BRIEF.md
# Failsafe Configuration Loader with Disarm Watchdog

This controller brings up a reprogrammable device from a flash that stores one protected recovery image (slot 0) and several user images (slots 1 to `N_USER`). After reset, or when the host asks for a reload, it reads the header of the chosen slot, rejects a user image whose header is malformed, and streams the payload bytes to the device configuration port. The device reports success or failure on two inputs.

A freshly loaded user image is trusted only once the host proves it is alive by writing a two-step key to the control register. Until then a watchdog runs. If the key does not arrive in time, the load reports an error, the done input never comes, or the header is bad, the controller reloads the recovery image from slot 0. That image is loaded without a header check and without a watchdog, so the host always keeps a path back to the flash. A sticky flag records that a recovery happened.

Top module: `cfg_guard`

## Requirements
- R1: While reset is high, `flash_rd`, `cfg_valid`, `wdt_armed`, `cfg_running` and `fallback_seen` are 0 and `cur_slot` is 0.
- R2: Slot s occupies flash bytes s*2^SLOT_AW upward. Byte 0 is a marker, bytes 1 and 2 are the payload length (low byte first), and the payload starts at byte 3. A user slot is accepted only if its marker is 0xC3, its length is non-zero and at most 2^SLOT_AW-3, and its index is at most `N_USER`.
- R3: An accepted image is presented on `cfg_data` one byte per cycle, with `cfg_valid` high for exactly `length` consecutive cycles, in ascending flash address order.
- R4: A rejected user slot produces no payload byte from that slot; the controller goes straight to recovery.
- R5: When `cfg_done` is seen after a user image has streamed, `wdt_armed` rises and the controller waits for the key.
- R6: While armed, a control-register write (address 0) of 0x5A followed by a control write of 0xA5 sets `cfg_running` and drops `wdt_armed`. Any other control value returns the key tracker to its start. Writes to other addresses neither advance nor reset it.
- R7: If the key is not completed, `wdt_armed` stays high for exactly `WDT_CYCLES` cycles and recovery follows.
- R8: `cfg_err` during streaming or while waiting for done, or no `cfg_done` within `LOAD_TMO` cycles of the end of streaming, starts recovery.
- R9: Recovery sets `cfg_running` low, selects slot 0 (`cur_slot`=0) and sets `fallback_seen`. It loads slot 0 without checking its header, and after `cfg_done` it goes directly to running without arming the watchdog.
- R10: `fallback_seen` stays high until the host writes a value with bit 0 set to address 2; writing there with bit 0 clear has no effect.
- R11: A write to address 1 with bit 7 set starts a load of the slot given by its low bits, but only while running; in any other state it is ignored.
- R12: After reset is released, slot `BOOT_SLOT` is loaded without any host action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flash_rd | output | 1 | Flash read strobe |
| flash_addr | output | SEL_W+SLOT_AW | Flash byte address |
| flash_q | input | 8 | Flash read data, valid one cycle after the strobe |
| cfg_valid | output | 1 | Configuration byte valid |
| cfg_data | output | 8 | Configuration byte |
| cfg_done | input | 1 | Device reports configuration complete |
| cfg_err | input | 1 | Device reports configuration error |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address (0 control, 1 load, 2 flag clear) |
| host_wdata | input | 8 | Host write data |
| cur_slot | output | SEL_W | Slot being loaded or loaded last |
| fallback_seen | output | 1 | Sticky recovery flag |
| wdt_armed | output | 1 | Watchdog running, key awaited |
| cfg_running | output | 1 | Image accepted and running |

## Verification
The hardest situations to reach from the ports are the edges of the key sequence and of the header check: a wrong control value between the two key bytes, a foreign-address write between them, and lengths one inside and one outside the slot. The stimulus reaches them by rewriting the bench flash image between reloads and by issuing host writes in back-to-back cycles while the watchdog is running. Timeouts are made short through parameters, so the exact armed and waiting durations can be counted at the ports. A behavioural model that reads the same flash array predicts every output on every cycle.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    localparam logic [7:0] IMG_MARKER  = 8'hC3;
    localparam logic [7:0] UNLOCK_KEY0 = 8'h5A;
    localparam logic [7:0] UNLOCK_KEY1 = 8'hA5;
    localparam int         HDR_BYTES   = 3;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_LOAD = 2'd1;
    localparam logic [1:0] REG_CLR  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOAD,
        ST_WAIT,
        ST_ARMED,
        ST_RUN,
        ST_FALLBACK
    } ldr_state_e;

    typedef struct packed {
        logic [7:0]  marker;
        logic [15:0] length;
    } img_hdr_t;

    function automatic logic hdr_valid(img_hdr_t h, logic [15:0] max_len);
        return (h.marker == IMG_MARKER) && (h.length != 16'd0) && (h.length <= max_len);
    endfunction

endpackage

// File: rtl/cfg_guard_hdr.sv
module cfg_guard_hdr
    import cfg_guard_pkg::*;
#(
    parameter int unsigned MAX_LEN = 4093
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_en,
    input  logic [1:0] cap_sel,
    input  logic [7:0] din,
    output img_hdr_t   hdr,
    output logic       hdr_ok
);

    logic [7:0] byte_q [HDR_BYTES];

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q[g] <= '0;
            end else if (cap_en && int'(cap_sel) == g) begin
                byte_q[g] <= din;
            end
        end
    end

    always_comb begin
        hdr.marker = byte_q[0];
        hdr.length = {byte_q[2], byte_q[1]};
        hdr_ok     = hdr_valid(hdr, 16'(MAX_LEN));
    end

endmodule

// File: rtl/cfg_guard_unlock.sv
module cfg_guard_unlock
    import cfg_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);

    logic step_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            step_q <= 1'b0;
        end else if (wr) begin
            step_q <= !step_q && (wdata == UNLOCK_KEY0);
        end
    end

    assign unlocked = wr && step_q && (wdata == UNLOCK_KEY1);

endmodule

// File: rtl/cfg_guard_timer.sv
module cfg_guard_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int unsigned N_USER     = 3,
    parameter int unsigned SLOT_AW    = 12,
    parameter int unsigned BOOT_SLOT  = 1,
    parameter int unsigned WDT_CYCLES = 32'h0100_0000,
    parameter int unsigned LOAD_TMO   = 65536,
    localparam int unsigned SEL_W     = $clog2(N_USER + 1),
    localparam int unsigned FA_W      = SEL_W + SLOT_AW
) (
    input  logic             clk,
    input  logic             rst,
    output logic             flash_rd,
    output logic [FA_W-1:0]  flash_addr,
    input  logic [7:0]       flash_q,
    output logic             cfg_valid,
    output logic [7:0]       cfg_data,
    input  logic             cfg_done,
    input  logic             cfg_err,
    input  logic             host_wr,
    input  logic [1:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [SEL_W-1:0] cur_slot,
    output logic             fallback_seen,
    output logic             wdt_armed,
    output logic             cfg_running
);

    localparam int unsigned SLOT_BYTES = 1 << SLOT_AW;
    localparam int unsigned MAX_LEN    = SLOT_BYTES - HDR_BYTES;
    localparam int unsigned TMR_MAX    = (WDT_CYCLES > LOAD_TMO) ? WDT_CYCLES : LOAD_TMO;
    localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);
    localparam logic [15:0] HDR_LAST   = 16'(HDR_BYTES + 1);

    ldr_state_e       state_q;
    logic [SEL_W-1:0] slot_q;
    logic [15:0]      idx_q;
    logic             fb_q;
    logic             pay_q;

    img_hdr_t         hdr;
    logic             hdr_ok;
    logic             cap_en;
    logic [1:0]       cap_sel;

    logic             unlocked;
    logic             ctrl_wr;
    logic             tmr_run;
    logic             tmr_clr;
    logic             tmr_exp;
    logic [TMR_W-1:0] tmr_limit;

    logic             load_req;
    logic             clr_req;
    logic             slot_in_range;
    logic [SLOT_AW-1:0] rd_off;

    // host decode
    assign load_req = host_wr && (host_addr == REG_LOAD) && host_wdata[7];
    assign clr_req  = host_wr && (host_addr == REG_CLR) && host_wdata[0];
    assign ctrl_wr  = host_wr && (host_addr == REG_CTRL) && (state_q == ST_ARMED);

    assign slot_in_range = int'(slot_q) <= int'(N_USER);

    // header capture: bytes arrive one cycle after each read
    assign cap_en  = (state_q == ST_CHECK) && (idx_q >= 16'd1) && (idx_q <= 16'(HDR_BYTES));
    assign cap_sel = 2'(idx_q - 16'd1);

    cfg_guard_hdr #(
        .MAX_LEN (MAX_LEN)
    ) u_hdr (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_sel (cap_sel),
        .din     (flash_q),
        .hdr     (hdr),
        .hdr_ok  (hdr_ok)
    );

    cfg_guard_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .clear    (state_q != ST_ARMED),
        .wr       (ctrl_wr),
        .wdata    (host_wdata),
        .unlocked (unlocked)
    );

    assign tmr_run   = (state_q == ST_WAIT) || (state_q == ST_ARMED);
    assign tmr_clr   = !tmr_run || ((state_q == ST_WAIT) && cfg_done);
    assign tmr_limit = (state_q == ST_ARMED) ? TMR_W'(WDT_CYCLES) : TMR_W'(LOAD_TMO);

    cfg_guard_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    // flash read port
    assign rd_off     = (state_q == ST_CHECK) ? idx_q[SLOT_AW-1:0]
                                              : idx_q[SLOT_AW-1:0] + SLOT_AW'(HDR_BYTES);
    assign flash_addr = {slot_q, rd_off};
    assign flash_rd   = ((state_q == ST_CHECK) && (idx_q < 16'(HDR_BYTES))) ||
                        (state_q == ST_LOAD);

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_q <= ST_CHECK;
                    slot_q  <= SEL_W'(BOOT_SLOT);
                    idx_q   <= '0;
                end
                ST_CHECK: begin
                    if (idx_q == HDR_LAST) begin
                        idx_q <= '0;
                        if (slot_q == '0) begin
                            state_q <= (hdr.length == 16'd0) ? ST_WAIT : ST_LOAD;
                        end else if (hdr_ok && slot_in_range) begin
                            state_q <= ST_LOAD;
                        end else begin
                            state_q <= ST_FALLBACK;
                        end
                    end else begin
                        idx_q <= idx_q + 16'd1;
                    end
                end
                ST_LOAD: begin
                    idx_q <= idx_q + 16'd1;
                    if (cfg_err) begin
                        state_q <= ST_FALLBACK;
                    end else if (idx_q == hdr.length - 16'd1) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cfg_err) begin
                        state_q <= ST_FALLBACK;
                    end else if (cfg_done) begin
                        state_q <= (slot_q == '0) ? ST_RUN : ST_ARMED;
                    end else if (tmr_exp) begin
                        state_q <= ST_FALLBACK;
                    end
                end
                ST_ARMED: begin
                    if (unlocked) begin
                        state_q <= ST_RUN;
                    end else if (tmr_exp) begin
                        state_q <= ST_FALLBACK;
                    end
                end
                ST_RUN: begin
                    if (load_req) begin
                        state_q <= ST_CHECK;
                        slot_q  <= host_wdata[SEL_W-1:0];
                        idx_q   <= '0;
                    end
                end
                ST_FALLBACK: begin
                    state_q <= ST_CHECK;
                    slot_q  <= '0;
                    idx_q   <= '0;
                end
                default: begin
                    state_q <= ST_FALLBACK;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_q  <= 1'b0;
            pay_q <= 1'b0;
        end else begin
            pay_q <= (state_q == ST_LOAD);
            if (state_q == ST_FALLBACK) begin
                fb_q <= 1'b1;
            end else if (clr_req) begin
                fb_q <= 1'b0;
            end
        end
    end

    assign cfg_valid     = pay_q;
    assign cfg_data      = pay_q ? flash_q : 8'h00;
    assign cur_slot      = slot_q;
    assign fallback_seen = fb_q;
    assign wdt_armed     = (state_q == ST_ARMED);
    assign cfg_running   = (state_q == ST_RUN);

endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
    import cfg_guard_pkg::*;
#(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned FA_W  = 14
) (
    input logic             clk,
    input logic             rst,
    input ldr_state_e       state,
    input logic [15:0]      idx,
    input logic             hdr_ok,
    input logic [FA_W-1:0]  flash_addr,
    input logic             cfg_done,
    input logic             host_wr,
    input logic [1:0]       host_addr,
    input logic [7:0]       host_wdata,
    input logic [SEL_W-1:0] cur_slot,
    input logic             fallback_seen,
    input logic             wdt_armed,
    input logic             cfg_running
);

    localparam logic [FA_W-1:0] ADDR_ONE = 1;

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && $past(state) == ST_LOAD) |-> flash_addr == $past(flash_addr) + ADDR_ONE); // R3

    AST_BAD_HDR_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && idx == 16'(HDR_BYTES + 1) && cur_slot != '0 && !hdr_ok) |=> state == ST_FALLBACK); // R4

    AST_ARM_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_armed) |-> ($past(cfg_done) && cur_slot != '0)); // R5

    AST_RUN_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_ARMED && state == ST_RUN) |->
        $past(host_wr && host_addr == REG_CTRL && host_wdata == UNLOCK_KEY1)); // R6

    AST_RECOVERY_SLOT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FALLBACK) |=> (cur_slot == '0 && fallback_seen)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fallback_seen && !(host_wr && host_addr == REG_CLR && host_wdata[0])) |=> fallback_seen); // R10

    AST_EXCLUSIVE_MODE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wdt_armed, cfg_running})); // R5

endmodule

bind cfg_guard cfg_guard_chk #(
    .SEL_W (SEL_W),
    .FA_W  (FA_W)
) i_cfg_guard_chk (
    .clk           (clk),
    .rst           (rst),
    .state         (state_q),
    .idx           (idx_q),
    .hdr_ok        (hdr_ok),
    .flash_addr    (flash_addr),
    .cfg_done      (cfg_done),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .cur_slot      (cur_slot),
    .fallback_seen (fallback_seen),
    .wdt_armed     (wdt_armed),
    .cfg_running   (cfg_running)
);

// File: tb/test_cfg_guard.sv
module test_cfg_guard;

    localparam int N_USER = 3;
    localparam int SLOT_AW = 6;
    localparam int BOOT = 1;
    localparam int WDT = 40;
    localparam int LTMO = 20;
    localparam int SB = 1 << SLOT_AW;
    localparam int MEM_N = (N_USER + 1) * SB;

    localparam int PH_IDLE = 0, PH_CHK = 1, PH_LOAD = 2, PH_WAIT = 3,
                   PH_ARM = 4, PH_RUN = 5, PH_FB = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flash_rd;
    logic [7:0] flash_addr;
    logic [7:0] flash_q = 8'h00;
    logic       cfg_valid;
    logic [7:0] cfg_data;
    logic       cfg_done = 1'b0;
    logic       cfg_err = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [1:0] cur_slot;
    logic       fallback_seen;
    logic       wdt_armed;
    logic       cfg_running;

    logic [7:0] mem [MEM_N];
    byte unsigned got [$];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state
    int m_ph = PH_IDLE, m_slot = 0, m_idx = 0, m_len = 0, m_tmr = 0;
    int m_step = 0, m_fb = 0, m_pv = 0, m_pd = 0;
    int old_ph, base, ok_hdr, key_done;

    cfg_guard #(
        .N_USER     (N_USER),
        .SLOT_AW    (SLOT_AW),
        .BOOT_SLOT  (BOOT),
        .WDT_CYCLES (WDT),
        .LOAD_TMO   (LTMO)
    ) i_cfg_guard (
        .clk           (clk),
        .rst           (rst),
        .flash_rd      (flash_rd),
        .flash_addr    (flash_addr),
        .flash_q       (flash_q),
        .cfg_valid     (cfg_valid),
        .cfg_data      (cfg_data),
        .cfg_done      (cfg_done),
        .cfg_err       (cfg_err),
        .host_wr       (host_wr),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .cur_slot      (cur_slot),
        .fallback_seen (fallback_seen),
        .wdt_armed     (wdt_armed),
        .cfg_running   (cfg_running)
    );

    always #5 clk = ~clk;

    // flash with one cycle of read latency
    always @(posedge clk) if (flash_rd) flash_q <= mem[flash_addr];

    function automatic int pay(int s, int i);
        return (s * 37 + i * 11 + 5) & 255;
    endfunction

    task automatic fill_slot(int s, int mk, int len);
        for (int i = 0; i < SB; i++) mem[s * SB + i] = 8'(pay(s, i - 3));
        mem[s * SB]     = 8'(mk);
        mem[s * SB + 1] = 8'(len & 255);
        mem[s * SB + 2] = 8'(len >> 8);
    endtask

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_ph = PH_IDLE; m_slot = 0; m_idx = 0; m_tmr = 0;
            m_step = 0; m_fb = 0; m_pv = 0; m_pd = 0;
        end else begin
            m_pv = (m_ph == PH_LOAD) ? 1 : 0;
            m_pd = mem[m_slot * SB + ((3 + m_idx) % SB)];
            old_ph = m_ph;
            if (old_ph == PH_FB) m_fb = 1;
            else if (host_wr && host_addr == 2'd2 && host_wdata[0]) m_fb = 0;
            case (old_ph)
                PH_IDLE: begin m_ph = PH_CHK; m_slot = BOOT; m_idx = 0; end
                PH_CHK: begin
                    if (m_idx == 4) begin
                        base = m_slot * SB;
                        m_len = mem[base + 1] + 256 * mem[base + 2];
                        ok_hdr = (mem[base] == 8'hC3 && m_len != 0 && m_len <= SB - 3 &&
                                  m_slot <= N_USER) ? 1 : 0;
                        m_idx = 0;
                        if (m_slot == 0) m_ph = (m_len == 0) ? PH_WAIT : PH_LOAD;
                        else m_ph = ok_hdr ? PH_LOAD : PH_FB;
                        m_tmr = 0;
                    end else m_idx++;
                end
                PH_LOAD: begin
                    if (cfg_err) m_ph = PH_FB;
                    else if (m_idx == m_len - 1) begin m_ph = PH_WAIT; m_tmr = 0; end
                    m_idx++;
                end
                PH_WAIT: begin
                    if (cfg_err) m_ph = PH_FB;
                    else if (cfg_done) begin
                        m_ph = (m_slot == 0) ? PH_RUN : PH_ARM;
                        m_tmr = 0; m_step = 0;
                    end else if (m_tmr == LTMO - 1) m_ph = PH_FB;
                    else m_tmr++;
                end
                PH_ARM: begin
                    key_done = 0;
                    if (host_wr && host_addr == 2'd0) begin
                        if (m_step == 1 && host_wdata == 8'hA5) key_done = 1;
                        m_step = (m_step == 0 && host_wdata == 8'h5A) ? 1 : 0;
                    end
                    if (key_done) m_ph = PH_RUN;
                    else if (m_tmr == WDT - 1) m_ph = PH_FB;
                    else m_tmr++;
                end
                PH_RUN: begin
                    if (host_wr && host_addr == 2'd1 && host_wdata[7]) begin
                        m_ph = PH_CHK; m_slot = host_wdata[1:0]; m_idx = 0;
                    end
                end
                PH_FB: begin m_ph = PH_CHK; m_slot = 0; m_idx = 0; end
                default: m_ph = PH_FB;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check_eq("R3 cfg_valid", int'(cfg_valid), m_pv);
            if (m_pv != 0) check_eq("R3 cfg_data", int'(cfg_data), m_pd);
            check_eq("R5 wdt_armed", int'(wdt_armed), (m_ph == PH_ARM) ? 1 : 0);
            check_eq("R6 cfg_running", int'(cfg_running), (m_ph == PH_RUN) ? 1 : 0);
            check_eq("R10 fallback_seen", int'(fallback_seen), m_fb);
            check_eq("R9 cur_slot", int'(cur_slot), m_slot);
            if (cfg_valid) got.push_back(cfg_data);
        end
    end

    task automatic hwrite(logic [1:0] a, logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_ph(int p);
        while (m_ph != p) @(negedge clk);
    endtask

    task automatic give_done();
        wait_ph(PH_WAIT);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    task automatic expect_stream(string tag, int s, int n);
        check_eq({tag, " byte count"}, got.size(), n);
        for (int i = 0; i < n && i < got.size(); i++)
            check_eq({tag, " byte"}, int'(got[i]), pay(s, i));
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int cnt;
        fill_slot(0, 8'h00, 4);
        fill_slot(1, 8'hC3, 5);
        fill_slot(2, 8'h3C, 5);
        fill_slot(3, 8'hC3, 6);

        // R1 reset state
        repeat (3) @(negedge clk);
        check_eq("R1 flash_rd", int'(flash_rd), 0);
        check_eq("R1 cfg_valid", int'(cfg_valid), 0);
        check_eq("R1 wdt_armed", int'(wdt_armed), 0);
        check_eq("R1 cfg_running", int'(cfg_running), 0);
        check_eq("R1 fallback_seen", int'(fallback_seen), 0);
        check_eq("R1 cur_slot", int'(cur_slot), 0);
        rst = 1'b0;

        // R12 automatic boot of the boot slot
        give_done();
        expect_stream("R12 boot", 1, 5);
        check_eq("R12 boot slot", int'(cur_slot), BOOT);
        check_eq("R5 armed after done", int'(wdt_armed), 1);

        // R11 reload request ignored while armed
        hwrite(2'd1, 8'h83);
        check_eq("R11 request ignored armed", int'(wdt_armed), 1);
        check_eq("R11 slot unchanged", int'(cur_slot), 1);

        // R6 wrong value restarts the key
        hwrite(2'd0, 8'h5A);
        hwrite(2'd0, 8'h33);
        hwrite(2'd0, 8'hA5);
        check_eq("R6 broken key stays armed", int'(wdt_armed), 1);
        hwrite(2'd0, 8'h5A);
        hwrite(2'd0, 8'h5A);
        hwrite(2'd0, 8'hA5);
        check_eq("R6 repeated first key stays armed", int'(wdt_armed), 1);
        // R6 foreign-address write between the key bytes
        hwrite(2'd0, 8'h5A);
        hwrite(2'd3, 8'h77);
        hwrite(2'd0, 8'hA5);
        check_eq("R6 key accepted", int'(cfg_running), 1);
        check_eq("R6 disarmed", int'(wdt_armed), 0);

        // R4 bad marker -> recovery, no user byte
        got.delete();
        hwrite(2'd1, 8'h82);
        give_done();
        expect_stream("R4 only recovery bytes", 0, 4);
        check_eq("R9 flag set", int'(fallback_seen), 1);
        check_eq("R9 recovery slot", int'(cur_slot), 0);
        check_eq("R9 running without arming", int'(cfg_running), 1);

        // R10 clear behaviour
        hwrite(2'd2, 8'h00);
        check_eq("R10 bit0 clear keeps flag", int'(fallback_seen), 1);
        hwrite(2'd2, 8'h01);
        check_eq("R10 flag cleared", int'(fallback_seen), 0);

        // R7 watchdog expiry
        got.delete();
        hwrite(2'd1, 8'h83);
        give_done();
        expect_stream("R3 slot3", 3, 6);
        check_eq("R11 slot3 selected", int'(cur_slot), 3);
        cnt = 0;
        while (wdt_armed) begin cnt++; @(negedge clk); end
        check_eq("R7 armed duration", cnt, WDT);
        give_done();
        check_eq("R7 recovery flag", int'(fallback_seen), 1);
        check_eq("R7 recovery running", int'(cfg_running), 1);
        hwrite(2'd2, 8'h01);

        // R8 error during streaming
        hwrite(2'd1, 8'h81);
        wait_ph(PH_LOAD);
        cfg_err = 1'b1;
        @(negedge clk);
        cfg_err = 1'b0;
        give_done();
        check_eq("R8 error recovery flag", int'(fallback_seen), 1);
        check_eq("R8 error recovery slot", int'(cur_slot), 0);
        hwrite(2'd2, 8'h01);

        // R8 done timeout
        hwrite(2'd1, 8'h81);
        wait_ph(PH_WAIT);
        cnt = 0;
        while (!fallback_seen) begin @(negedge clk); cnt++; end
        check_eq("R8 load timeout cycles", cnt, LTMO + 1);
        give_done();
        hwrite(2'd2, 8'h01);

        // R2 largest length accepted
        fill_slot(1, 8'hC3, SB - 3);
        got.delete();
        hwrite(2'd1, 8'h81);
        give_done();
        check_eq("R2 max length armed", int'(wdt_armed), 1);
        expect_stream("R3 max length", 1, SB - 3);
        hwrite(2'd0, 8'h5A);
        hwrite(2'd0, 8'hA5);
        check_eq("R6 running after max length", int'(cfg_running), 1);

        // R2 one byte too long
        fill_slot(1, 8'hC3, SB - 2);
        got.delete();
        hwrite(2'd1, 8'h81);
        give_done();
        check_eq("R2 overlong rejected", int'(fallback_seen), 1);
        expect_stream("R4 overlong no user byte", 0, 4);
        hwrite(2'd2, 8'h01);

        // R2 zero length
        fill_slot(1, 8'hC3, 0);
        hwrite(2'd1, 8'h81);
        give_done();
        check_eq("R2 zero length rejected", int'(fallback_seen), 1);
        check_eq("R9 zero length slot", int'(cur_slot), 0);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule